// File: doc/BRIEF.md
# External Memory Bus Sequencer

This block connects an 8-bit core to external memory over a narrow, time-shared bus. The core presents one request at a time: a code fetch, a data read or a data write, each carrying a 16-bit address. Every external access follows the same sequence. The low address byte is driven on a shared 8-bit bus while a latch strobe is high, so that an outside latch can capture it. The latch strobe then drops and the same bus carries the data. The high address byte stays on its own port for the whole access.

Code space and data space are both 64 KB and are told apart only by the strobe that is used. Fetches pulse a code strobe. Data reads and writes pulse separate read and write strobes. All three strobes are active-low.

A mode input selects how low code addresses are handled. When `use_int_rom` is high, fetches below a parameter limit (4 KB by default) are served by on-chip ROM and produce no bus activity. The block only reports that the ROM should answer. When `use_int_rom` is low, every fetch goes out on the bus.

Top module: `xbus_seq`

## Requirements
- R1: After reset the block is idle: `ale`=0, `psen_n`=`rd_n`=`wr_n`=1, `ad_oe`=0, `busy`=0, `done`=0.
- R2: An external access begins with ADDR_CLKS cycles in which `ale`=1, `ad_oe`=1, `ad_out` equals address bits 7:0, and no strobe is low.
- R3: `hi_addr` equals address bits 15:8 in every cycle of an external access.
- R4: A fetch (`req_kind`=2'b00) drives `psen_n` low for STROBE_CLKS cycles. `rdata` then holds the `ad_in` value present in the last of those cycles.
- R5: A data read (`req_kind`=2'b01) drives `rd_n` low for STROBE_CLKS cycles. `ad_oe` is 0 while `rd_n` is low, and `rdata` returns the bus value from the last strobe cycle.
- R6: A data write (`req_kind`=2'b10) drives `wr_n` low for STROBE_CLKS cycles. Throughout that time `ad_oe`=1 and `ad_out` equals the write byte.
- R7: A fetch with `use_int_rom`=1 and an address below ROM_LIMIT (0x1000) produces no bus cycle. `done` and `int_hit` both pulse in the cycle after acceptance.
- R8: With `use_int_rom`=1, a fetch at ROM_LIMIT or above goes external. With `use_int_rom`=0, every fetch goes external, including address 0x0000.
- R9: An accepted external request raises `busy` until its strobe is released. `done` pulses for one cycle, 1+ADDR_CLKS+STROBE_CLKS cycles after the accepting edge, with `busy`=0. Requests made while `busy` is high are ignored.
- R10: A request with `req_kind`=2'b11 is ignored: no strobe, no `ale`, no `done`.
- R11: A request presented during the `done` cycle is accepted at the next edge.
- R12: At most one of the three strobes is low at any time, and none is low while `ale` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_kind | input | 2 | 00 fetch, 01 read, 10 write, 11 reserved |
| req_addr | input | 16 | Request address |
| req_wdata | input | 8 | Write byte |
| use_int_rom | input | 1 | High: low code addresses are served internally |
| busy | output | 1 | External access in progress |
| done | output | 1 | One-cycle completion pulse |
| int_hit | output | 1 | With done: the fetch belongs to internal ROM |
| rdata | output | 8 | Byte captured by the last read or fetch |
| ad_out | output | 8 | Shared bus drive value |
| ad_oe | output | 1 | Shared bus drive enable |
| ad_in | input | 8 | Shared bus sampled value |
| hi_addr | output | 8 | High address byte port |
| ale | output | 1 | Address latch strobe |
| psen_n | output | 1 | Code read strobe, active low |
| rd_n | output | 1 | Data read strobe, active low |
| wr_n | output | 1 | Data write strobe, active low |

## Verification
Two functions can fall in the same cycle. The first is completion of one access together with acceptance of the next. The bench provokes this by raising an internal fetch in the cycle where `done` is high, then expects a second `done`, now with `int_hit` set, one cycle later.

The second is a new request arriving while the current access is still running. The bench provokes this by presenting a write in the middle of an external read. It judges the result by the absence of any `wr_n` pulse, by the read data still being correct, and by no extra `done` appearing afterwards.

// File: rtl/xbus_seq.sv
module xbus_seq #(
  parameter int ADDR_CLKS   = 1,
  parameter int STROBE_CLKS = 3,
  parameter int ROM_LIMIT   = 4096
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  input  logic [1:0]  req_kind,
  input  logic [15:0] req_addr,
  input  logic [7:0]  req_wdata,
  input  logic        use_int_rom,
  output logic        busy,
  output logic        done,
  output logic        int_hit,
  output logic [7:0]  rdata,
  output logic [7:0]  ad_out,
  output logic        ad_oe,
  input  logic [7:0]  ad_in,
  output logic [7:0]  hi_addr,
  output logic        ale,
  output logic        psen_n,
  output logic        rd_n,
  output logic        wr_n
);
  localparam int MAXC = (ADDR_CLKS > STROBE_CLKS) ? ADDR_CLKS : STROBE_CLKS;
  localparam int CW   = (MAXC > 1) ? $clog2(MAXC) : 1;
  localparam logic [CW-1:0] ADDR_LAST = CW'(ADDR_CLKS - 1);
  localparam logic [CW-1:0] STRB_LAST = CW'(STROBE_CLKS - 1);
  localparam logic [1:0] K_FETCH = 2'b00, K_READ = 2'b01, K_WRITE = 2'b10, K_NONE = 2'b11;

  typedef enum logic [1:0] {S_IDLE, S_ADDR, S_STRB} st_t;

  st_t         st;
  logic [CW-1:0] cnt;
  logic [1:0]  kind_q;
  logic [15:0] addr_q;
  logic [7:0]  wdata_q;

  wire accept   = (st == S_IDLE) && req_valid && (req_kind != K_NONE);
  wire internal = (req_kind == K_FETCH) && use_int_rom &&
                  ({16'h0, req_addr} < 32'(ROM_LIMIT));
  wire strobing = (st == S_STRB);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      cnt     <= '0;
      kind_q  <= K_FETCH;
      addr_q  <= '0;
      wdata_q <= '0;
      rdata   <= '0;
      done    <= 1'b0;
      int_hit <= 1'b0;
    end else begin
      done    <= 1'b0;
      int_hit <= 1'b0;
      unique case (st)
        S_IDLE: if (accept) begin
          if (internal) begin
            done    <= 1'b1;
            int_hit <= 1'b1;
          end else begin
            st      <= S_ADDR;
            cnt     <= '0;
            kind_q  <= req_kind;
            addr_q  <= req_addr;
            wdata_q <= req_wdata;
          end
        end
        S_ADDR: if (cnt == ADDR_LAST) begin
          st  <= S_STRB;
          cnt <= '0;
        end else cnt <= cnt + 1'b1;
        S_STRB: if (cnt == STRB_LAST) begin
          st   <= S_IDLE;
          cnt  <= '0;
          done <= 1'b1;
          if (kind_q != K_WRITE) rdata <= ad_in;
        end else cnt <= cnt + 1'b1;
        default: st <= S_IDLE;
      endcase
    end
  end

  assign busy    = (st != S_IDLE);
  assign ale     = (st == S_ADDR);
  assign ad_oe   = ale || (strobing && kind_q == K_WRITE);
  assign ad_out  = ale ? addr_q[7:0] : wdata_q;
  assign hi_addr = busy ? addr_q[15:8] : 8'h00;
  assign psen_n  = !(strobing && kind_q == K_FETCH);
  assign rd_n    = !(strobing && kind_q == K_READ);
  assign wr_n    = !(strobing && kind_q == K_WRITE);

  a_r12_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({~psen_n, ~rd_n, ~wr_n}) <= 1);
  a_r12_no_strobe_in_addr: assert property (@(posedge clk) disable iff (!rst_n)
    ale |-> (psen_n && rd_n && wr_n));
  a_r2_addr_driven: assert property (@(posedge clk) disable iff (!rst_n)
    ale |-> ad_oe);
  a_r5_bus_released: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_n |-> !ad_oe);
  a_r6_write_driven: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_n |-> (ad_oe && ad_out == wdata_q));
  a_r9_done_not_busy: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
  a_r2_strobe_follows_ale: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ale) |-> !(psen_n && rd_n && wr_n));
  a_r3_hi_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(hi_addr));
  a_r7_hit_with_done: assert property (@(posedge clk) disable iff (!rst_n)
    int_hit |-> done);
endmodule

// File: tb/tb_xbus_seq.sv
module tb_xbus_seq;
  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic [1:0] req_kind = 2'b00;
  logic [15:0] req_addr = '0;
  logic [7:0] req_wdata = '0;
  logic use_int_rom = 1'b1;
  logic busy, done, int_hit, ad_oe, ale, psen_n, rd_n, wr_n;
  logic [7:0] rdata, ad_out, hi_addr, ad_in, lat_lo;
  int checks = 0, errors = 0;
  int n_ale, n_ps, n_rd, n_wr, bad_lo, bad_hi, bad_w, bad_r, bad_mix, n_done;
  logic [15:0] exp_a;
  logic [7:0] exp_w;

  always #4 clk = ~clk;

  xbus_seq dut (.clk, .rst_n, .req_valid, .req_kind, .req_addr, .req_wdata,
    .use_int_rom, .busy, .done, .int_hit, .rdata, .ad_out, .ad_oe, .ad_in,
    .hi_addr, .ale, .psen_n, .rd_n, .wr_n);

  assign ad_in = ~lat_lo ^ hi_addr;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  always @(negedge clk) if (rst_n) begin
    if (ale) begin
      n_ale++;
      lat_lo = ad_out;
      if (ad_out != exp_a[7:0] || !ad_oe) bad_lo++;
    end
    if (busy && hi_addr != exp_a[15:8]) bad_hi++;
    if (!psen_n) n_ps++;
    if (!rd_n) n_rd++;
    if (!wr_n) begin n_wr++; if (!ad_oe || ad_out != exp_w) bad_w++; end
    if ((!rd_n || !psen_n) && ad_oe) bad_r++;
    if (ale && !(psen_n && rd_n && wr_n)) bad_mix++;
    if ($countones({~psen_n, ~rd_n, ~wr_n}) > 1) bad_mix++;
    if (done) n_done++;
  end

  task automatic clr();
    n_ale = 0; n_ps = 0; n_rd = 0; n_wr = 0; bad_lo = 0; bad_hi = 0;
    bad_w = 0; bad_r = 0; bad_mix = 0; n_done = 0;
  endtask

  task automatic issue(input [1:0] k, input [15:0] a, input [7:0] w, input e);
    @(negedge clk);
    exp_a = a; exp_w = w; clr();
    req_valid = 1; req_kind = k; req_addr = a; req_wdata = w; use_int_rom = e;
    @(negedge clk);
    req_valid = 0;
  endtask

  task automatic wait_done(output int lat);
    lat = 0;
    for (int n = 1; n <= 20; n++) begin
      #1;
      if (done) begin lat = n; return; end
      @(negedge clk);
    end
  endtask

  task automatic t_reset();
    chk(!ale && psen_n && rd_n && wr_n && !ad_oe && !busy && !done, "R1 idle after reset",
        {ale, psen_n, rd_n, wr_n, ad_oe, busy, done}, 7'b0111000);
  endtask

  task automatic t_ext(input [1:0] k, input [15:0] a, input [7:0] w, input e, input string tag);
    int lat;
    issue(k, a, w, e);
    wait_done(lat);
    chk(lat == 5, {tag, " R9 latency"}, lat, 5);
    chk(!busy && !int_hit, {tag, " R9 done not busy"}, {busy, int_hit}, 0);
    chk(n_ale == 1 && bad_lo == 0, {tag, " R2 address phase"}, n_ale, 1);
    chk(bad_hi == 0, {tag, " R3 high byte"}, bad_hi, 0);
    chk(bad_mix == 0, {tag, " R12 strobe exclusivity"}, bad_mix, 0);
    case (k)
      2'b00: begin
        chk(n_ps == 3 && n_rd == 0 && n_wr == 0, {tag, " R4 code strobe"}, n_ps, 3);
        chk(rdata == (~a[7:0] ^ a[15:8]), {tag, " R4 fetch data"}, rdata, ~a[7:0] ^ a[15:8]);
      end
      2'b01: begin
        chk(n_rd == 3 && n_ps == 0 && n_wr == 0 && bad_r == 0, {tag, " R5 read strobe"}, n_rd, 3);
        chk(rdata == (~a[7:0] ^ a[15:8]), {tag, " R5 read data"}, rdata, ~a[7:0] ^ a[15:8]);
      end
      default:
        chk(n_wr == 3 && n_ps == 0 && n_rd == 0 && bad_w == 0, {tag, " R6 write strobe"}, n_wr, 3);
    endcase
  endtask

  task automatic t_internal(input [15:0] a);
    int lat;
    issue(2'b00, a, 8'h00, 1'b1);
    wait_done(lat);
    chk(lat == 1 && int_hit, "R7 internal fetch done", lat, 1);
    repeat (2) @(negedge clk);
    chk(n_ale == 0 && n_ps == 0 && n_rd == 0 && n_wr == 0, "R7 no bus activity", n_ale + n_ps, 0);
  endtask

  task automatic t_reserved();
    issue(2'b11, 16'h3456, 8'h00, 1'b0);
    repeat (7) @(negedge clk);
    chk(n_ale == 0 && n_ps + n_rd + n_wr == 0 && n_done == 0 && !busy,
        "R10 reserved kind ignored", n_ale + n_done, 0);
  endtask

  task automatic t_busy_req();
    int lat;
    issue(2'b01, 16'h2345, 8'h00, 1'b1);
    req_valid = 1; req_kind = 2'b10; req_addr = 16'h7777; req_wdata = 8'hEE;
    @(negedge clk);
    req_valid = 0;
    wait_done(lat);
    chk(rdata == (~8'h45 ^ 8'h23), "R9 read survives busy request", rdata, ~8'h45 ^ 8'h23);
    repeat (7) @(negedge clk);
    chk(n_wr == 0 && n_done == 1 && n_ale == 1, "R9 request while busy ignored", n_wr + n_done, 1);
  endtask

  task automatic t_back_to_back();
    int lat;
    issue(2'b00, 16'h8001, 8'h00, 1'b1);
    wait_done(lat);
    req_valid = 1; req_kind = 2'b00; req_addr = 16'h0100; use_int_rom = 1;
    @(negedge clk);
    req_valid = 0;
    #1;
    chk(done && int_hit, "R11 request in done cycle accepted", {done, int_hit}, 3);
  endtask

  initial begin
    #(8 * 200000);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    exp_a = '0; exp_w = '0; lat_lo = '0; clr();
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_ext(2'b00, 16'h1234, 8'h00, 1'b1, "fetch high");
    t_ext(2'b00, 16'h1000, 8'h00, 1'b1, "R8 fetch at limit");
    t_ext(2'b00, 16'h0000, 8'h00, 1'b0, "R8 forced external");
    t_ext(2'b00, 16'h0FFF, 8'h00, 1'b0, "R8 forced external top");
    t_internal(16'h0FFF);
    t_internal(16'h0000);
    t_ext(2'b01, 16'hABCD, 8'h00, 1'b1, "read");
    t_ext(2'b01, 16'h0010, 8'h00, 1'b1, "read low addr");
    t_ext(2'b10, 16'hFF00, 8'hA5, 1'b1, "write");
    t_ext(2'b10, 16'h0055, 8'h3C, 1'b0, "write low");
    t_reserved();
    t_busy_req();
    t_back_to_back();
    repeat (3) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule